// File: doc/BRIEF.md
# Dual 12-Bit Converter Code Loader

This block holds the digital codes for two 12-bit converter channels that are loaded over an 8-bit parallel bus. Each channel has a staging pair: an 8-bit low part and a 4-bit high part. Each channel also has a 12-bit output register that drives the converter code. A host writes the staging registers with chip-select and write strobes, and two address lines pick the register.

A separate update strobe, qualified by write, copies both staged codes into the output registers on the same clock edge. Both converters therefore change together. An active-low asynchronous clear zeroes every register. All strobes are sampled as levels on the system clock.

Top module: `dual_dac_loader`

## Requirements
- R1: While `clr_n` is low, every staging register and both outputs are zero. Assertion of `clr_n` takes effect without waiting for a clock edge.
- R2: A write with `addr` = 2'b00 stores `din[7:0]` in the low 8 bits of channel A's staged code. With `addr` = 2'b10 it stores them in channel B's staged code.
- R3: A write with `addr` = 2'b01 (channel A) or 2'b11 (channel B) stores `din[3:0]` as bits 11..8 of the staged code. `din[7:4]` is ignored.
- R4: A staging register is written only in a clock cycle where `cs_n` and `wr_n` are both low. With either one high, no staged value changes.
- R5: The outputs change only in a cycle where `upd_n` and `wr_n` are both low. Staging writes alone leave `code_a` and `code_b` unchanged.
- R6: An update loads both channels on the same edge: `code_a` and `code_b` take the full 12-bit staged codes {high, low}.
- R7: An update with `cs_n` high writes no staging register.
- R8: When `cs_n`, `wr_n` and `upd_n` are all low together, the outputs take the staged codes held before that cycle. The addressed staging register takes the new bus data in the same cycle.
- R9: Clear overrides any write or update presented during it.
- R10: `upd_n` low with `wr_n` high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes sampled on rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of all registers |
| cs_n | input | 1 | Active-low chip select for staging writes |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low update strobe, qualified by wr_n |
| addr | input | 2 | Staging register select {channel, high part} |
| din | input | 8 | Parallel data bus |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |

## Verification
A staging write and an output update can fall in the same clock cycle. The bench provokes this by sweeping all eight combinations of `cs_n`, `wr_n` and `upd_n` against every address, with staged values differing from the bus data. It judges the result on the outputs right after the edge: they must show the old staged code. The newly written byte is then exposed by a later pure update. Clear is also asserted together with all strobes, to show it wins over both.

// File: rtl/dual_dac_loader.sv
module dual_dac_loader #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  din,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  localparam int HI_W = CODE_W - BUS_W;

  logic [BUS_W-1:0]  lo_q    [2];
  logic [HI_W-1:0]   hi_q    [2];
  logic [CODE_W-1:0] stage_q [2];
  logic [CODE_W-1:0] out_q   [2];

  wire load_en = !cs_n && !wr_n;
  wire upd_en  = !upd_n && !wr_n;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    wire sel_lo = load_en && (addr == 2'(2*ch));
    wire sel_hi = load_en && (addr == 2'(2*ch+1));

    always_ff @(posedge clk or negedge clr_n)
      if (!clr_n)      lo_q[ch] <= '0;
      else if (sel_lo) lo_q[ch] <= din;

    always_ff @(posedge clk or negedge clr_n)
      if (!clr_n)      hi_q[ch] <= '0;
      else if (sel_hi) hi_q[ch] <= din[HI_W-1:0];

    assign stage_q[ch] = {hi_q[ch], lo_q[ch]};

    always_ff @(posedge clk or negedge clr_n)
      if (!clr_n)      out_q[ch] <= '0;
      else if (upd_en) out_q[ch] <= stage_q[ch];
  end

  assign code_a = out_q[0];
  assign code_b = out_q[1];
endmodule

module dual_dac_loader_chk #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input logic              clk,
  input logic              clr_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic              upd_n,
  input logic [1:0]        addr,
  input logic [BUS_W-1:0]  din,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic [CODE_W-1:0] stage_a,
  input logic [CODE_W-1:0] stage_b
);
  localparam int HI_W = CODE_W - BUS_W;

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    !clr_n |-> (code_a == '0 && code_b == '0 && stage_a == '0 && stage_b == '0));

  // R2
  lo_write_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && !wr_n && addr == 2'b00) |=>
      (stage_a[BUS_W-1:0] == $past(din) && $stable(stage_b) && $stable(stage_a[CODE_W-1:BUS_W])));

  // R3
  hi_write_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && !wr_n && addr == 2'b11) |=>
      (stage_b[CODE_W-1:BUS_W] == $past(din[HI_W-1:0]) && $stable(stage_a) && $stable(stage_b[BUS_W-1:0])));

  // R4
  no_write_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (cs_n || wr_n) |=> ($stable(stage_a) && $stable(stage_b)));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (wr_n || upd_n) |=> ($stable(code_a) && $stable(code_b)));

  // R6
  upd_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_n && !upd_n) |=> (code_a == $past(stage_a) && code_b == $past(stage_b)));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
  .addr(addr), .din(din), .code_a(code_a), .code_b(code_b),
  .stage_a(stage_q[0]), .stage_b(stage_q[1])
);

// File: tb/sim_dual_dac_loader.sv
module sim_dual_dac_loader;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [11:0] code_a, code_b;

  int n_run = 0, n_fail = 0;

  logic [7:0]  m_lo [2];
  logic [3:0]  m_hi [2];
  logic [11:0] m_out [2];

  always #10 clk = ~clk;

  dual_dac_loader u0 (.clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .upd_n(upd_n), .addr(addr), .din(din), .code_a(code_a), .code_b(code_b));

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %03h expected %03h", tag, got, exp);
    end
  endtask

  task automatic check_both(string tag);
    check({tag, " A"}, code_a, m_out[0]);
    check({tag, " B"}, code_b, m_out[1]);
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin m_lo[c] = '0; m_hi[c] = '0; m_out[c] = '0; end
  endtask

  // one clock cycle of strobes; model follows R2..R8, R10
  task automatic bus(logic c, logic w, logic u, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = c; wr_n = w; upd_n = u; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; upd_n = 1'b1;
    if (!w && !u)
      for (int k = 0; k < 2; k++) m_out[k] = {m_hi[k], m_lo[k]};
    if (!c && !w) begin
      if (a[0]) m_hi[a[1]] = d[3:0];
      else      m_lo[a[1]] = d;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check_both("R1 reset");
    clr_n = 1'b1;

    // R2 R3 R6: sweep codes on both channels, upper din bits set as junk
    for (int v = 0; v < 4096; v += 37) begin
      logic [11:0] va, vb;
      va = 12'(v); vb = 12'(4095 - v);
      bus(0, 0, 1, 2'b00, va[7:0]);
      bus(0, 0, 1, 2'b01, {4'hA, va[11:8]});
      bus(0, 0, 1, 2'b10, vb[7:0]);
      check_both("R5 no update yet");
      bus(0, 0, 1, 2'b11, {4'h5, vb[11:8]});
      bus(1, 0, 0, 2'b00, 8'hFF);
      check("R6 R2 R3 code A", code_a, va);
      check("R6 R2 R3 code B", code_b, vb);
    end

    // R4 R7 R8 R10: every strobe combination on every address
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 4; a++) begin
        logic [7:0] d;
        d = 8'(s * 29 + a * 71 + 13);
        bus(0, 0, 1, 2'(a), ~d);
        bus(s[2], s[1], s[0], 2'(a), d);
        check_both("R4 R7 R8 R10 strobe combo");
        bus(1, 0, 0, 2'b00, 8'h00);
        check_both("R4 R7 R8 staged after combo");
      end

    // R9: clear held across an edge with all strobes active
    bus(0, 0, 1, 2'b00, 8'h5A);
    bus(1, 0, 0, 2'b00, 8'h00);
    @(negedge clk);
    cs_n = 0; wr_n = 0; upd_n = 0; addr = 2'b01; din = 8'h0F;
    clr_n = 1'b0;
    #1;
    model_clear();
    check_both("R1 async clear");
    @(negedge clk);
    check_both("R9 clear over strobes");
    cs_n = 1; wr_n = 1; upd_n = 1;
    clr_n = 1'b1;
    bus(1, 0, 0, 2'b00, 8'h00);
    check_both("R1 R9 staging cleared");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule